// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a general purpose register file that software sees as 32 logical registers, while the storage behind them is larger. The low ten logical numbers always reach the same ten global registers, whatever procedure is running. The upper 22 logical numbers reach a window into a circular physical array of 128 registers. A three-bit current window pointer selects where that window sits. Consecutive windows are 16 physical registers apart, so each window shares six registers with the one above it and six with the one below it. A caller places arguments in its top six window registers, and the callee finds them in its bottom six, with no memory traffic.

Two combinational read ports and one write port take logical register numbers. A call strobe moves the pointer up one window and a return strobe moves it down one. A count of windows holding live state drives two one-cycle flags. The overflow flag tells the surrounding logic that a call has wrapped onto a live window and must be spilled. The underflow flag tells it that a return has landed in a window whose contents must be refilled. The block only raises these flags. It moves no data to or from memory.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 0 to 9 are global. A value written to one of them from any window reads back the same from every other window.
- R2: Logical register r in the range 10 to 31 addresses physical window slot (cwp*16 + r - 10) mod 128. Logical 26..31 in window w are therefore the same storage as logical 10..15 in window (w+1) mod 8, and 16..25 of a window are reachable from no other window.
- R3: When call_i is high and ret_i is low, cwp_o becomes (cwp_o+1) mod 8 on the next rising edge. When ret_i is high and call_i is low, it becomes (cwp_o-1) mod 8.
- R4: When call_i and ret_i are both high, or both low, cwp_o, the resident count and both flags behave as for no strobe.
- R5: The resident count starts at 1 and rises by one per call, up to 7. A call made while it is 7 sets overflow_o high for exactly the following cycle. The pointer still advances and the count stays at 7.
- R6: A return falls the resident count by one, down to 1. A return made while it is 1 sets underflow_o high for exactly the following cycle. The pointer still moves back and the count stays at 1.
- R7: A read of the logical register being written in the same cycle returns the new wr_data on that port in that cycle (write-first).
- R8: After the synchronous active-high reset, cwp_o is 0, both flags are low, the resident count is 1 and every register reads 0.
- R9: With wr_en low nothing is written. A write always uses the pointer value held during its own cycle, even when a call or return in that cycle moves the pointer at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Procedure call strobe, advances the window |
| ret_i | input | 1 | Procedure return strobe, retreats the window |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | 32 | Write data |
| rd_addr_a | input | 5 | Logical register for read port A |
| rd_data_a | output | 32 | Read port A data, combinational |
| rd_addr_b | input | 5 | Logical register for read port B |
| rd_data_b | output | 32 | Read port B data, combinational |
| cwp_o | output | 3 | Current window pointer |
| overflow_o | output | 1 | One-cycle pulse, call onto a live window |
| underflow_o | output | 1 | One-cycle pulse, return with no resident caller |

## Verification
A pointer that is off by one shows up on the next read of any windowed register. The data seen there belongs to a neighbouring window. It shows up at once on cwp_o too. A translation error that leaves the offsets inside a window intact appears only when data crosses windows. Examples are arguments passed through the six shared registers, or a wrap from window 7 back to window 0. A wrong resident count is silent until the first call or return at a boundary, where a flag pulse is missing, duplicated or early. The reference model tracks the count independently, so that pulse is compared in the cycle it should appear.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

    parameter int DATA_W      = 32;
    parameter int NUM_GLOBALS = 10;
    parameter int WIN_REGS    = 22;
    parameter int OVERLAP     = 6;
    parameter int NUM_WIN     = 8;
    parameter int NUM_RD      = 2;

    localparam int LOG_REGS  = NUM_GLOBALS + WIN_REGS;
    localparam int STRIDE    = WIN_REGS - OVERLAP;
    localparam int PHYS_REGS = STRIDE * NUM_WIN;
    localparam int LADDR_W   = $clog2(LOG_REGS);
    localparam int PADDR_W   = $clog2(PHYS_REGS);
    localparam int GADDR_W   = $clog2(NUM_GLOBALS);
    localparam int CWP_W     = $clog2(NUM_WIN);
    localparam int RES_W     = $clog2(NUM_WIN + 1);
    localparam int RES_MAX   = NUM_WIN - 1;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [LADDR_W-1:0] laddr_t;
    typedef logic [CWP_W-1:0]   cwp_t;
    typedef logic [RES_W-1:0]   res_t;

    typedef enum logic [1:0] {
        WOP_HOLD,
        WOP_CALL,
        WOP_RET
    } win_op_t;

    // Physical target of one access; unused fields are held at zero so
    // two targets can be compared as whole vectors.
    typedef struct packed {
        logic                 is_global;
        logic [GADDR_W-1:0]   gidx;
        logic [PADDR_W-1:0]   widx;
    } ptarget_t;

    function automatic ptarget_t map_reg(input laddr_t r, input cwp_t c);
        ptarget_t t;
        int       slot;
        t = '0;
        if (int'(r) < NUM_GLOBALS) begin
            t.is_global = 1'b1;
            t.gidx      = GADDR_W'(r);
        end else begin
            slot   = int'(c) * STRIDE + int'(r) - NUM_GLOBALS;
            slot   = slot % PHYS_REGS;
            t.widx = PADDR_W'(slot);
        end
        return t;
    endfunction

    function automatic win_op_t decode_op(input logic call_s, input logic ret_s);
        if (call_s && !ret_s) return WOP_CALL;
        if (ret_s && !call_s) return WOP_RET;
        return WOP_HOLD;
    endfunction

endpackage

// File: rtl/rwf_window_ctrl.sv
module rwf_window_ctrl
    import rwf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic call_i,
    input  logic ret_i,
    output cwp_t cwp_o,
    output logic overflow_o,
    output logic underflow_o
);

    win_op_t op;
    cwp_t    cwp_q;
    res_t    res_q;
    logic    ovf_q;
    logic    unf_q;

    assign op = decode_op(call_i, ret_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            res_q <= res_t'(1);
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            unique case (op)
                WOP_CALL: begin
                    cwp_q <= cwp_q + cwp_t'(1);
                    if (res_q == res_t'(RES_MAX)) ovf_q <= 1'b1;
                    else                          res_q <= res_q + res_t'(1);
                end
                WOP_RET: begin
                    cwp_q <= cwp_q - cwp_t'(1);
                    if (res_q == res_t'(1)) unf_q <= 1'b1;
                    else                    res_q <= res_q - res_t'(1);
                end
                default: ;
            endcase
        end
    end

    assign cwp_o       = cwp_q;
    assign overflow_o  = ovf_q;
    assign underflow_o = unf_q;

endmodule

// File: rtl/rwf_addr_map.sv
module rwf_addr_map
    import rwf_pkg::*;
(
    input  laddr_t   laddr,
    input  cwp_t     cwp,
    output ptarget_t tgt
);

    assign tgt = map_reg(laddr, cwp);

endmodule

// File: rtl/rwf_storage.sv
module rwf_storage
    import rwf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  ptarget_t wr_tgt,
    input  word_t    wr_data,
    input  ptarget_t rd_tgt  [NUM_RD],
    output word_t    rd_data [NUM_RD]
);

    word_t glob_q [NUM_GLOBALS];
    word_t win_q  [PHYS_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_GLOBALS; i++) glob_q[i] <= '0;
            for (int j = 0; j < PHYS_REGS; j++)   win_q[j]  <= '0;
        end else if (wr_en) begin
            if (wr_tgt.is_global) glob_q[wr_tgt.gidx] <= wr_data;
            else                  win_q[wr_tgt.widx]  <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        word_t raw;
        logic  hit;
        assign raw = rd_tgt[p].is_global ? glob_q[rd_tgt[p].gidx]
                                         : win_q[rd_tgt[p].widx];
        assign hit = wr_en && (rd_tgt[p] == wr_tgt);
        assign rd_data[p] = hit ? wr_data : raw;
    end

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import rwf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        call_i,
    input  logic        ret_i,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [4:0]  rd_addr_a,
    output logic [31:0] rd_data_a,
    input  logic [4:0]  rd_addr_b,
    output logic [31:0] rd_data_b,
    output logic [2:0]  cwp_o,
    output logic        overflow_o,
    output logic        underflow_o
);

    cwp_t     cwp;
    ptarget_t wr_tgt;
    laddr_t   rd_addr [NUM_RD];
    ptarget_t rd_tgt  [NUM_RD];
    word_t    rd_word [NUM_RD];

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    rwf_window_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .call_i      (call_i),
        .ret_i       (ret_i),
        .cwp_o       (cwp),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    rwf_addr_map u_wmap (
        .laddr (wr_addr),
        .cwp   (cwp),
        .tgt   (wr_tgt)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rmap
        rwf_addr_map u_rmap (
            .laddr (rd_addr[p]),
            .cwp   (cwp),
            .tgt   (rd_tgt[p])
        );
    end

    rwf_storage u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_tgt  (wr_tgt),
        .wr_data (wr_data),
        .rd_tgt  (rd_tgt),
        .rd_data (rd_word)
    );

    assign rd_data_a = rd_word[0];
    assign rd_data_b = rd_word[1];
    assign cwp_o     = cwp;

endmodule

// File: rtl/rwf_checker.sv
module rwf_checker (
    input logic        clk,
    input logic        rst,
    input logic        call_i,
    input logic        ret_i,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [4:0]  rd_addr_a,
    input logic [31:0] rd_data_a,
    input logic [4:0]  rd_addr_b,
    input logic [31:0] rd_data_b,
    input logic [2:0]  cwp_o,
    input logic        overflow_o,
    input logic        underflow_o
);

    p_reset_state_r8: assert property (@(posedge clk)
        rst |=> (cwp_o == 3'd0 && !overflow_o && !underflow_o));

    p_call_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i) |=> cwp_o == 3'($past(cwp_o) + 3'd1));

    p_ret_retreat_r3: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i) |=> cwp_o == 3'($past(cwp_o) - 3'd1));

    p_no_move_r4: assert property (@(posedge clk) disable iff (rst)
        (call_i == ret_i) |=> $stable(cwp_o) && !overflow_o && !underflow_o);

    p_ovf_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_o) |-> $past(call_i && !ret_i));

    p_unf_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(underflow_o) |-> $past(ret_i && !call_i));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({overflow_o, underflow_o}));

    p_bypass_a_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_addr_a == wr_addr) |-> rd_data_a == wr_data);

    p_bypass_b_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_addr_b == wr_addr) |-> rd_data_b == wr_data);

endmodule

bind regwin_file rwf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr_a   (rd_addr_a),
    .rd_data_a   (rd_data_a),
    .rd_addr_b   (rd_addr_b),
    .rd_data_b   (rd_data_b),
    .cwp_o       (cwp_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
);

// File: tb/regwin_file_tb.sv
`timescale 1ns/1ps
module regwin_file_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        call_i, ret_i, wr_en;
    logic [4:0]  wr_addr, rd_addr_a, rd_addr_b;
    logic [31:0] wr_data, rd_data_a, rd_data_b;
    logic [2:0]  cwp_o;
    logic        overflow_o, underflow_o;

    always #10 clk = ~clk;

    regwin_file u_dut (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .cwp_o(cwp_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    // Behavioural reference state
    logic [31:0] m_glob [10];
    logic [31:0] m_win  [128];
    int          m_cwp;
    int          m_res;
    bit          m_ovf, m_unf;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input int r, input bit we, input int wa,
                                          input logic [31:0] wd);
        if (we && wa == r) return wd;
        if (r < 10) return m_glob[r];
        return m_win[(m_cwp * 16 + r - 10) % 128];
    endfunction

    task automatic step(input bit c, input bit r, input bit we, input int wa,
                        input logic [31:0] wd, input int ra, input int rb,
                        input string tag);
        @(negedge clk);
        call_i = c; ret_i = r; wr_en = we;
        wr_addr = 5'(wa); wr_data = wd; rd_addr_a = 5'(ra); rd_addr_b = 5'(rb);
        #1;
        check(tag, rd_data_a, m_read(ra, we, wa, wd));
        check(tag, rd_data_b, m_read(rb, we, wa, wd));
        check("R3 cwp", 32'(cwp_o), 32'(m_cwp));
        check("R5 overflow", 32'(overflow_o), 32'(m_ovf));
        check("R6 underflow", 32'(underflow_o), 32'(m_unf));
        @(posedge clk);
        if (we) begin
            if (wa < 10) m_glob[wa] = wd;
            else         m_win[(m_cwp * 16 + wa - 10) % 128] = wd;
        end
        m_ovf = 1'b0;
        m_unf = 1'b0;
        if (c && !r) begin
            m_cwp = (m_cwp + 1) % 8;
            if (m_res == 7) m_ovf = 1'b1; else m_res++;
        end else if (r && !c) begin
            m_cwp = (m_cwp + 7) % 8;
            if (m_res == 1) m_unf = 1'b1; else m_res--;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; call_i = 0; ret_i = 0; wr_en = 0;
        wr_addr = 0; wr_data = 0; rd_addr_a = 0; rd_addr_b = 0;
        for (int i = 0; i < 10; i++)  m_glob[i] = '0;
        for (int i = 0; i < 128; i++) m_win[i]  = '0;
        m_cwp = 0; m_res = 1; m_ovf = 0; m_unf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: every register of window 0 reads zero after reset
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 2 * i, 2 * i + 1, "R8 reset read");

        // R1: fill globals from window 0
        for (int i = 0; i < 10; i++) step(0, 0, 1, i, 32'hA000_0000 + i, i, 0, "R1 global write");
        // R2: fill windowed registers of window 0
        for (int i = 10; i < 32; i++) step(0, 0, 1, i, 32'hB000_0000 + i, i, 31, "R2 window write");

        // R9: write together with call uses the old window
        step(1, 0, 1, 20, 32'hC0DE_0020, 20, 26, "R9 write with call");
        // R2: window 1 sees old r26..31 at r10..15
        for (int i = 10; i < 16; i++) step(0, 0, 0, 0, 0, i, i + 10, "R2 overlap");
        // R9: disabled write leaves register alone
        step(0, 0, 0, 12, 32'hDEAD_DEAD, 12, 3, "R9 write disabled");
        step(0, 0, 0, 0, 0, 12, 12, "R9 after disabled write");
        // R7: write-first on both ports, windowed and global
        step(0, 0, 1, 17, 32'h1234_5678, 17, 17, "R7 bypass window");
        step(0, 0, 1, 4, 32'h8765_4321, 4, 5, "R7 bypass global");
        // R4: both strobes hold the window
        step(1, 1, 0, 0, 0, 17, 4, "R4 both strobes");
        step(0, 0, 0, 0, 0, 17, 4, "R4 after both strobes");

        // R5: climb through all windows and wrap; globals stay visible (R1)
        for (int i = 0; i < 10; i++) step(1, 0, 1, 26 + (i % 6), 32'hD000_0000 + i, i, 26, "R1 global across calls");
        // R2: wrap from window 7 to window 0 aliasing
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 10 + (i % 6), 30, "R2 read after wrap");
        // R6: unwind past the bottom
        for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 0, 10, 26, "R6 unwind read");
        step(0, 0, 0, 0, 0, 4, 15, "R6 after unwind");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int  sel = int'($urandom % 8);
            step(sel == 0, sel == 1 || sel == 2 && ($urandom % 2 == 1),
                 ($urandom % 2) == 1, int'($urandom % 32), $urandom,
                 int'($urandom % 32), int'($urandom % 32), "R2 random traffic");
        end

        // R8: reset in mid-run clears state again
        @(negedge clk);
        rst = 1'b1; call_i = 0; ret_i = 0; wr_en = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 10; i++)  m_glob[i] = '0;
        for (int i = 0; i < 128; i++) m_win[i]  = '0;
        m_cwp = 0; m_res = 1; m_ovf = 0; m_unf = 0;
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 2 * i, 2 * i + 1, "R8 second reset");
        step(0, 1, 0, 0, 0, 0, 0, "R6 underflow after reset");
        step(0, 0, 0, 0, 0, 0, 0, "R6 underflow pulse");

        done = 1'b1;
        finish_run();
    end

endmodule